// File: doc/BRIEF.md
# Bus Hold Arbitration Control

This block owns the control word of a processor's main external bus and runs the handshake through which an outside master asks for that bus. An external agent raises an active-high request. If software has not locked such requests out, the block sets a status flag and raises an acknowledge output. From then on the bus drivers elsewhere on the chip release the bus. When the request falls, the block hands the bus back.

Software reaches the control word through a 32-bit register port with per-byte write enables. Two bits of the word steer arbitration. A lockout bit refuses outside requests. A float bit lets software put the bus into high impedance on its own initiative. The status flag is shared by the two kinds of release: one started by an outside request and one started by software. Each kind has its own rule for ending the release. A request that arrives while the lockout bit is set waits. It is granted at the moment software clears that bit.

Top module: `bus_hold_arbiter`

## Requirements
- R1: After reset the register reads 0x000010F8 and `holdAck` is low.
- R2: The request is registered at one clock edge. When the registered request rises and the lockout bit (bit 1) is clear, the status bit (bit 0) and `holdAck` are set at the next edge, so `holdAck` goes high two edges after `holdReq` is applied.
- R3: A rising request while the lockout bit is set changes neither the status bit nor `holdAck`.
- R4: When the registered request falls while the status bit is set and the float bit (bit 2) is clear, the status bit and `holdAck` are cleared at the next edge.
- R5: When the registered request falls while the float bit is set, the status bit and `holdAck` keep their values.
- R6: A write that changes the float bit inverts the status bit at that edge, and `holdAck` takes the new value of the float bit.
- R7: A write that clears a set lockout bit while the registered request is high sets the status bit and `holdAck` at that edge.
- R8: A write updates only the bits of the bytes whose `byteEn` bit is set (bit i covers data bits 8i+7..8i). Bit 0 is never written, and nothing changes when `wrEn` is low.
- R9: `rdData` always shows the whole register in the same cycle, including the current status bit.
- R10: A write that leaves the float bit unchanged does not alter the status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data |
| byteEn | input | 4 | Per-byte write enables |
| rdData | output | 32 | Current register contents |
| holdReq | input | 1 | External bus request, active high |
| holdAck | output | 1 | Bus release acknowledge, active high |

## Verification
The directed patterns each separate one release path from the others. They cover a plain request and drop, a request held off by the lockout bit and then granted when the bit is cleared, and a software float that blocks the release that would normally follow a dropped request. Byte-enable writes of all ones show that masked bytes and bit 0 keep their values. They also show that a float change inverts the status bit rather than setting it. A random phase then mixes request toggles with writes that land on request edges. This tells apart the order in which a hold event and a write of the same cycle are combined.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;

  // strobes from control to the register datapath
  typedef struct packed {
    logic stLoad;
    logic stVal;
  } ctlStrobes_t;

  // register state and write effects reported by the datapath
  typedef struct packed {
    logic status;
    logic noHold;
    logic hiZ;
    logic hiZChanged;
    logic hiZNew;
    logic noHoldCleared;
  } regFlags_t;

endpackage

// File: rtl/bus_hold_sampler.sv
module bus_hold_sampler (
  input  logic clk,
  input  logic rstN,
  input  logic reqIn,
  output logic reqQ,
  output logic reqRise,
  output logic reqFall
);
  logic reqP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ <= 1'b0;
      reqP <= 1'b0;
    end else begin
      reqQ <= reqIn;
      reqP <= reqQ;
    end
  end

  assign reqRise = reqQ & ~reqP;
  assign reqFall = ~reqQ & reqP;
endmodule

// File: rtl/bus_hold_regs.sv
module bus_hold_regs
  import bus_hold_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] RESET_VAL = 32'h0000_10F8,
  parameter logic [31:0] WR_MASK   = 32'hFFFF_FFFE,
  parameter int          ST_BIT    = 0,
  parameter int          NH_BIT    = 1,
  parameter int          HZ_BIT    = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [DATA_W-1:0]      wrData,
  input  logic [DATA_W/8-1:0]    byteEn,
  input  ctlStrobes_t            strobes,
  output logic [DATA_W-1:0]      regQ,
  output regFlags_t              flags
);
  localparam int NUM_BYTES = DATA_W / 8;

  logic [DATA_W-1:0] byteMask;
  logic [DATA_W-1:0] effMask;
  logic [DATA_W-1:0] merged;
  logic [DATA_W-1:0] regD;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byteMask
    assign byteMask[8*b +: 8] = {8{byteEn[b]}};
  end

  assign effMask = wrEn ? (byteMask & WR_MASK[DATA_W-1:0]) : '0;
  assign merged  = (regQ & ~effMask) | (wrData & effMask);

  always_comb begin
    regD = merged;
    if (strobes.stLoad) regD[ST_BIT] = strobes.stVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) regQ <= RESET_VAL[DATA_W-1:0];
    else       regQ <= regD;
  end

  assign flags.status        = regQ[ST_BIT];
  assign flags.noHold        = regQ[NH_BIT];
  assign flags.hiZ           = regQ[HZ_BIT];
  assign flags.hiZChanged    = merged[HZ_BIT] ^ regQ[HZ_BIT];
  assign flags.hiZNew        = merged[HZ_BIT];
  assign flags.noHoldCleared = regQ[NH_BIT] & ~merged[NH_BIT];
endmodule

// File: rtl/bus_hold_ctl.sv
module bus_hold_ctl
  import bus_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        holdReq,
  input  regFlags_t   flags,
  output ctlStrobes_t strobes,
  output logic        holdAck
);
  logic reqQ;
  logic reqRise;
  logic reqFall;
  logic grantEv;
  logic releaseEv;
  logic unholdEv;
  logic stNext;
  logic ackNext;

  bus_hold_sampler sampler_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqIn   (holdReq),
    .reqQ    (reqQ),
    .reqRise (reqRise),
    .reqFall (reqFall)
  );

  assign grantEv   = reqRise & ~flags.noHold;
  assign releaseEv = reqFall & flags.status & ~flags.hiZ;
  assign unholdEv  = flags.noHoldCleared & reqQ;

  // hold events first, then the effects of a write in the same cycle
  always_comb begin
    stNext  = flags.status;
    ackNext = holdAck;
    if (grantEv) begin
      stNext  = 1'b1;
      ackNext = 1'b1;
    end else if (releaseEv) begin
      stNext  = 1'b0;
      ackNext = 1'b0;
    end
    if (flags.hiZChanged) begin
      stNext  = ~stNext;
      ackNext = flags.hiZNew;
    end
    if (unholdEv) begin
      stNext  = 1'b1;
      ackNext = 1'b1;
    end
  end

  assign strobes.stLoad = stNext != flags.status;
  assign strobes.stVal  = stNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdAck <= 1'b0;
    else       holdAck <= ackNext;
  end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
  import bus_hold_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  input  logic [3:0]  byteEn,
  output logic [31:0] rdData,
  input  logic        holdReq,
  output logic        holdAck
);
  ctlStrobes_t strobes;
  regFlags_t   flags;

  bus_hold_regs #(
    .DATA_W    (32),
    .RESET_VAL (32'h0000_10F8),
    .WR_MASK   (32'hFFFF_FFFE),
    .ST_BIT    (0),
    .NH_BIT    (1),
    .HZ_BIT    (2)
  ) regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .byteEn  (byteEn),
    .strobes (strobes),
    .regQ    (rdData),
    .flags   (flags)
  );

  bus_hold_ctl ctl_i (
    .clk     (clk),
    .rstN    (rstN),
    .holdReq (holdReq),
    .flags   (flags),
    .strobes (strobes),
    .holdAck (holdAck)
  );
endmodule

// File: rtl/bus_hold_arbiter_chk.sv
module bus_hold_arbiter_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [3:0]  byteEn,
  input logic [31:0] rdData,
  input logic        holdReq,
  input logic        holdAck
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R2
  hold_grant_delay_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && $rose(holdAck) && !$past(wrEn)) |-> $past(holdReq, 2));

  // R3
  lockout_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && $rose(holdAck)) |-> ($past(wrEn) || !$past(rdData[1])));

  // R5
  float_keeps_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && !$past(wrEn) && $past(rdData[2])) |-> (!$fell(holdAck) && !$fell(rdData[0])));

  // R8
  idle_write_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && !$past(wrEn)) |-> $stable(rdData[31:3]));

  // R8
  byte_mask_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && !$past(byteEn[3])) |-> $stable(rdData[31:24]));
endmodule

bind bus_hold_arbiter bus_hold_arbiter_chk chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .byteEn  (byteEn),
  .rdData  (rdData),
  .holdReq (holdReq),
  .holdAck (holdAck)
);

// File: tb/bus_hold_arbiter_tb_top.sv
module bus_hold_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [31:0] wrData;
  logic [3:0]  byteEn;
  logic [31:0] rdData;
  logic        holdReq;
  logic        holdAck;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model state
  logic [31:0] mReg;
  logic        mAck, mQ, mP;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hold_arbiter dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .byteEn(byteEn),
    .rdData(rdData), .holdReq(holdReq), .holdAck(holdAck)
  );

  function automatic logic [31:0] maskOf(input logic we, input logic [3:0] be);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (be[b]) m[8*b +: 8] = 8'hFF;
    m = m & 32'hFFFF_FFFE;
    return we ? m : 32'h0;
  endfunction

  task automatic modelEdge();
    logic [31:0] m, merged;
    logic st, ack;
    m      = maskOf(wrEn, byteEn);
    merged = (mReg & ~m) | (wrData & m);
    st     = mReg[0];
    ack    = mAck;
    if (mQ && !mP && !mReg[1]) begin st = 1'b1; ack = 1'b1; end
    else if (!mQ && mP && mReg[0] && !mReg[2]) begin st = 1'b0; ack = 1'b0; end
    if (merged[2] != mReg[2]) begin st = ~st; ack = merged[2]; end
    if (mReg[1] && !merged[1] && mQ) begin st = 1'b1; ack = 1'b1; end
    mReg = {merged[31:1], st};
    mAck = ack;
    mP   = mQ;
    mQ   = holdReq;
  endtask

  task automatic modelReset();
    mReg = 32'h0000_10F8; mAck = 1'b0; mQ = 1'b0; mP = 1'b0;
  endtask

  // one clock: inputs held from the previous negedge, model follows the edge
  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic check1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [31:0] d, input logic [3:0] be);
    wrEn = 1'b1; wrData = d; byteEn = be;
    tick();
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      finishRun();
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; byteEn = '0; holdReq = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1
    check32("R1 reset value", rdData, 32'h0000_10F8);
    check1("R1 reset ack", holdAck, 1'b0);

    // R2: request, ack two edges later
    holdReq = 1'b1;
    tick();
    check1("R2 ack not before sampling", holdAck, 1'b0);
    tick();
    check1("R2 ack granted", holdAck, 1'b1);
    check1("R9 status readable", rdData[0], 1'b1);

    // R4: release
    holdReq = 1'b0;
    tick();
    check1("R4 ack held one edge", holdAck, 1'b1);
    tick();
    check1("R4 ack released", holdAck, 1'b0);
    check32("R4 status cleared", rdData, 32'h0000_10F8);

    // R3: lockout bit set, request refused
    doWrite(32'h0000_10FA, 4'b0001);
    holdReq = 1'b1;
    tick(); tick(); tick();
    check1("R3 ack refused", holdAck, 1'b0);
    check32("R3 status clear", rdData, 32'h0000_10FA);

    // R7: clearing lockout grants pending request
    doWrite(32'h0000_10F8, 4'b0001);
    check1("R7 ack on unlock", holdAck, 1'b1);
    check32("R7 status on unlock", rdData, 32'h0000_10F9);

    holdReq = 1'b0;
    tick(); tick();
    check1("R4 release after unlock", holdAck, 0);

    // R6: float bit set toggles status, ack follows float
    doWrite(32'h0000_10FC, 4'b0001);
    check32("R6 float set status", rdData, 32'h0000_10FD);
    check1("R6 float set ack", holdAck, 1'b1);

    // R5: request pulse while floated, release blocked
    holdReq = 1'b1;
    tick(); tick();
    holdReq = 1'b0;
    tick(); tick(); tick();
    check1("R5 ack kept", holdAck, 1'b1);
    check32("R5 status kept", rdData, 32'h0000_10FD);

    // R6: float cleared toggles status back
    doWrite(32'h0000_10F8, 4'b0001);
    check32("R6 float clear status", rdData, 32'h0000_10F8);
    check1("R6 float clear ack", holdAck, 1'b0);

    // R8: byte enables and protected bit 0 (float change also toggles status)
    doWrite(32'hFFFF_FFFF, 4'b0101);
    check32("R8 masked write", rdData, 32'h00FF_10FF);
    check1("R8 ack after float", holdAck, 1'b1);

    // R10: write without float change keeps status
    doWrite(32'hAB00_0000, 4'b1000);
    check32("R10 status unchanged", rdData, 32'hABFF_10FF);

    // R8: wrEn low changes nothing
    wrData = 32'h0; byteEn = 4'hF;
    tick();
    check32("R8 no write when idle", rdData, 32'hABFF_10FF);

    // random phase with model
    rstN = 1'b0;
    @(negedge clk);
    modelReset();
    rstN = 1'b1;
    @(negedge clk);
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(5) == 0) holdReq = ~holdReq;
      if ($urandom_range(7) == 0) begin
        wrEn   = 1'b1;
        wrData = {$urandom_range(65535), 13'h0870, 1'($urandom_range(1)),
                  1'($urandom_range(1)), 1'($urandom_range(1))};
        byteEn = 4'($urandom_range(15));
      end
      tick();
      check32("R9 model register", rdData, mReg);
      check1("R2 model ack", holdAck, mAck);
    end

    done = 1;
    finishRun();
  end
endmodule